// File: doc/BRIEF.md
# Serial-Load DAC Input Register

This block is the digital front end of a 10-bit voltage DAC. A host sends one data word over three wires: an active-low select, a serial clock and a serial data line. While select is low, the block samples the data line on each rising edge of the serial clock, taking the least significant bit first. When the tenth bit arrives, the block moves the assembled word into the output register without any separate strobe. It then ignores the serial clock until select goes high and comes low again.

The host writes the word in two's complement, centred on mid-scale. The block passes the word to the converter core as straight binary, so 0 is zero scale and 1023 is full scale. To get there it inverts the most significant bit when it commits the word. A sleep input is passed through to the core as a power-down output.

All three serial pins and the sleep pin are asynchronous to the system clock. Each goes through a two-flop synchroniser, and the block detects edges in the system clock domain. For this reason the serial clock must stay high, and stay low, for at least two system clock periods.

Top module: `sdac_serial_load`

## Requirements
- R1: While select (`sel_n_i`) is high, toggling `sclk_i` and `sdata_i` does not change `dac_code_o` and does not advance the load of a later word.
- R2: After select goes low, the block samples `sdata_i` on each rising edge of `sclk_i`. The first bit sampled is bit 0 of the word and the tenth is bit 9.
- R3: On the first nine rising edges of a load cycle, `dac_code_o` keeps its previous value.
- R4: The tenth rising edge commits the word. `dac_code_o` becomes the word with bit 9 inverted: input 10'h200 gives 0, input 10'h000 gives 512, input 10'h1FF gives 1023, and input 10'h3FF gives 511.
- R5: After a commit, further `sclk_i` edges are ignored while select stays low. They neither change `dac_code_o` nor shift into the next word. Only a rise of select followed by a new fall starts another load.
- R6: A rise of select clears the bit count and the lockout, and discards any partial word. If a load is aborted before its tenth bit, `dac_code_o` is unchanged.
- R7: While `rst_i` is high, and after it is released, `dac_code_o` is 512 (input code 0, mid-scale) and `pwr_down_o` is 0.
- R8: `pwr_down_o` follows `sleep_i` two system clock edges later. Sleep never alters `dac_code_o`, and a word loaded during sleep is still committed.
- R9: Suppose `sclk_i` rises for the tenth time between two system clock edges. `dac_code_o` still holds its old value after the second following clock edge and shows the new code after the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Active-low select/load, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, LSB first, asynchronous |
| sleep_i | input | 1 | Power-down request, asynchronous |
| dac_code_o | output | DATA_W | Straight-binary code to the converter core |
| pwr_down_o | output | 1 | Power-down indication to the converter core |

## Verification
A wrong bit count makes the block commit early or late. At the ports this shows as a wrong or shifted code, three clock edges after the serial edge that should have committed, or as an update while the output should still be holding. A lockout flag that stays clear lets extra serial edges leak into the next word, and the next load then shows a corrupted code. A partial word that a select rise fails to clear corrupts the first word loaded after an abort. The bench sends a known word after each of these disturbances, so any such fault reaches `dac_code_o` within one load cycle.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  // Asynchronous pins gathered so that they can share one synchroniser.
  typedef struct packed {
    logic sclk;
    logic sdata;
    logic sel_n;
    logic sleep;
  } sdac_pins_t;

  localparam int SDAC_PINS = $bits(sdac_pins_t);

  // Idle levels: deselected, clock low, awake.
  localparam sdac_pins_t PINS_RST = '{sclk: 1'b0, sdata: 1'b0, sel_n: 1'b1, sleep: 1'b0};

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) stg[g] <= RST_VAL;
        else       stg[g] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i) begin
        if (rst_i) stg[g] <= RST_VAL;
        else       stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/sdac_edge.sv
module sdac_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lvl_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= RST_VAL;
    else       prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int W = 10,
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             sel_active_i,
  input  logic             sel_rise_i,
  input  logic             sclk_rise_i,
  input  logic             sdata_i,
  output logic             commit_o,
  output logic [W-1:0]     word_o,
  output logic             locked_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     shreg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             lock_q;
  logic             take;

  assign take     = sel_active_i & ~lock_q & sclk_rise_i;
  assign commit_o = take & (cnt_q == LAST);
  // New bit enters at the top; after W shifts the first bit sits at bit 0.
  assign word_o   = {sdata_i, shreg_q[W-1:1]};
  assign locked_o = lock_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      lock_q  <= 1'b0;
    end else if (sel_rise_i) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      lock_q  <= 1'b0;
    end else if (take) begin
      shreg_q <= word_o;
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        lock_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdac_outreg.sv
module sdac_outreg #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         commit_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] code_o
);

  // Mid-scale: two's complement zero, i.e. only the top bit set in straight binary.
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  always_ff @(posedge clk_i) begin
    if (rst_i)         code_o <= MID;
    else if (commit_i) code_o <= {~word_i[W-1], word_i[W-2:0]};
  end

endmodule

// File: rtl/sdac_serial_load.sv
module sdac_serial_load #(
  parameter int DATA_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              sel_n_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              sleep_i,
  output logic [DATA_W-1:0] dac_code_o,
  output logic              pwr_down_o
);

  import sdac_pkg::*;

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  sdac_pins_t        pins_raw, pins_s;
  logic              sel_rise_w, sclk_rise_w, commit_w, locked_w;
  logic [DATA_W-1:0] word_w;
  logic [CNT_W-1:0]  cnt_w;

  assign pins_raw = {sclk_i, sdata_i, sel_n_i, sleep_i};

  sdac_sync #(
    .WIDTH  (SDAC_PINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_RST)
  ) u_sync (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .d_i  (pins_raw),
    .q_o  (pins_s)
  );

  sdac_edge #(.RST_VAL(1'b1)) u_sel_edge (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .lvl_i (pins_s.sel_n),
    .rise_o(sel_rise_w)
  );

  sdac_edge #(.RST_VAL(1'b0)) u_sclk_edge (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .lvl_i (pins_s.sclk),
    .rise_o(sclk_rise_w)
  );

  sdac_shift #(.W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .sel_active_i(~pins_s.sel_n),
    .sel_rise_i  (sel_rise_w),
    .sclk_rise_i (sclk_rise_w),
    .sdata_i     (pins_s.sdata),
    .commit_o    (commit_w),
    .word_o      (word_w),
    .locked_o    (locked_w),
    .cnt_o       (cnt_w)
  );

  sdac_outreg #(.W(DATA_W)) u_out (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .commit_i(commit_w),
    .word_i  (word_w),
    .code_o  (dac_code_o)
  );

  assign pwr_down_o = pins_s.sleep;

endmodule

// File: rtl/sdac_serial_load_chk.sv
module sdac_serial_load_chk #(
  parameter int W     = 10,
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             sel_n_s,
  input logic             sel_rise,
  input logic             commit,
  input logic             locked,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [W-1:0]     dac_code
);

  AST_DESELECTED_NO_COMMIT: assert property (@(posedge clk_i) disable iff (rst_i)
    sel_n_s |-> !commit); // R1

  AST_COUNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    bit_cnt < CNT_W'(W)); // R3

  AST_CODE_MOVES_ONLY_ON_COMMIT: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(dac_code) |-> $past(commit)); // R4

  AST_LOCK_AFTER_COMMIT: assert property (@(posedge clk_i) disable iff (rst_i)
    commit |=> locked); // R5

  AST_NO_COMMIT_WHILE_LOCKED: assert property (@(posedge clk_i) disable iff (rst_i)
    locked |-> !commit); // R5

  AST_SEL_RISE_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    sel_rise |=> (!locked && bit_cnt == '0)); // R6

endmodule

bind sdac_serial_load sdac_serial_load_chk #(.W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .sel_n_s (pins_s.sel_n),
  .sel_rise(sel_rise_w),
  .commit  (commit_w),
  .locked  (locked_w),
  .bit_cnt (cnt_w),
  .dac_code(dac_code_o)
);

// File: tb/sdac_serial_load_test.sv
module sdac_serial_load_test;

  localparam int W    = 10;
  localparam int HALF = 3;
  localparam int NVEC = 8;
  localparam logic [W-1:0] VEC_IN  [NVEC] = '{10'h200, 10'h000, 10'h1FF, 10'h3FF,
                                              10'h155, 10'h2AA, 10'h001, 10'h201};
  localparam logic [W-1:0] VEC_EXP [NVEC] = '{10'h000, 10'h200, 10'h3FF, 10'h1FF,
                                              10'h355, 10'h0AA, 10'h201, 10'h001};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1, sclk = 1'b0, sdata = 1'b0, sleep = 1'b0;
  logic [W-1:0] code;
  logic pd;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdac_serial_load uut (
    .clk_i(clk), .rst_i(rst), .sel_n_i(sel_n), .sclk_i(sclk),
    .sdata_i(sdata), .sleep_i(sleep), .dac_code_o(code), .pwr_down_o(pd)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    sdata = b;
    wait_n(HALF);
    sclk = 1'b1;
    wait_n(HALF);
    sclk = 1'b0;
  endtask

  task automatic select();
    sel_n = 1'b0;
    wait_n(4);
  endtask

  task automatic deselect();
    sel_n = 1'b1;
    wait_n(5);
  endtask

  task automatic send(input logic [W-1:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) pulse(w[i]);
    wait_n(2);
  endtask

  task automatic load(input logic [W-1:0] w);
    select();
    send(w, W);
    deselect();
  endtask

  initial begin
    wait_n(3);
    check("R7", "code held in reset", code, 512);
    check("R7", "power-down in reset", pd, 0);
    rst = 1'b0;
    wait_n(3);
    check("R7", "code after reset", code, 512);
    check("R7", "power-down after reset", pd, 0);

    // Table: R2 (LSB first) and R4 (commit with top bit inverted)
    for (int v = 0; v < NVEC; v++) begin
      load(VEC_IN[v]);
      check("R4", $sformatf("vector %0d code", v), code, VEC_EXP[v]);
    end

    // R1: clocks while deselected are ignored
    for (int i = 0; i < 12; i++) pulse(1'b1);
    wait_n(3);
    check("R1", "code after deselected clocks", code, 10'h001);
    load(10'h0F0);
    check("R1", "word after deselected clocks", code, 10'h2F0);

    // R3: nine bits leave the output alone, the tenth commits
    select();
    send(10'h30F, W - 1);
    check("R3", "code after nine bits", code, 10'h2F0);
    send(10'h30F >> (W - 1), 1);
    check("R2", "code after tenth bit", code, 10'h10F);
    deselect();

    // R5: extra clocks after commit are ignored and do not leak
    select();
    send(10'h0C3, W);
    check("R4", "code before extra clocks", code, 10'h2C3);
    for (int i = 0; i < 5; i++) pulse(1'b1);
    wait_n(3);
    check("R5", "code after extra clocks", code, 10'h2C3);
    deselect();
    load(10'h246);
    check("R5", "next word after lockout", code, 10'h046);

    // R6: aborted partial word
    select();
    send(10'h3FF, 5);
    deselect();
    check("R6", "code after abort", code, 10'h046);
    load(10'h0AA);
    check("R6", "word after abort", code, 10'h2AA);

    // R9: latency from the tenth serial edge
    select();
    send(10'h3A5, W - 1);
    sdata = 1'b1;
    wait_n(HALF);
    sclk = 1'b1;
    wait_n(2);
    check("R9", "code two edges after tenth rise", code, 10'h2AA);
    wait_n(1);
    check("R9", "code three edges after tenth rise", code, 10'h1A5);
    wait_n(HALF);
    sclk = 1'b0;
    deselect();

    // R8: sleep pass-through without touching the code
    sleep = 1'b1;
    wait_n(1);
    check("R8", "power-down after one edge", pd, 0);
    wait_n(1);
    check("R8", "power-down after two edges", pd, 1);
    check("R8", "code unchanged by sleep", code, 10'h1A5);
    load(10'h1FF);
    check("R8", "word loaded during sleep", code, 10'h3FF);
    sleep = 1'b0;
    wait_n(3);
    check("R8", "power-down released", pd, 0);
    check("R8", "code unchanged by wake", code, 10'h3FF);

    // R7: reset mid-run returns to mid-scale
    rst = 1'b1;
    wait_n(2);
    check("R7", "code after late reset", code, 512);
    rst = 1'b0;
    wait_n(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule